// File: doc/BRIEF.md
# Nine-Level Stacked-Carrier PWM Modulator

The block drives a single-phase nine-level inverter built from two unequal isolated sources and eight power switches. On every modulation tick it compares a signed reference sample with eight triangular carriers. The carriers sit on top of one another in equal, non-overlapping amplitude bands. The number of carriers that the reference lies strictly above, less four, gives the output level, from -4 to +4. A fixed table turns that level into the eight-bit gate pattern for the switch network.

All eight carriers come from one shared up/down sweep counter. Each carrier is either the counter value added to the floor of its band, or the counter value mirrored inside the band. This mirroring gives the 180-degree inverted carrier. A two-bit mode input chooses which bands are mirrored. The choices are all in phase, opposed across zero, or alternately opposed. The carrier period is the same in every mode. The reference generator sets the tick rate so that one carrier period lasts one twentieth of the reference period. The same generator supplies the sine samples. Dead-time insertion happens after this block.

Top module: `lsc_pwm_nine`

## Requirements
- R1: The level code is the count of carriers that `refIn` is strictly greater than, minus 4, so it lies in the range -4 to +4. A reference equal to a carrier does not count for that carrier. A reference above every carrier gives +4, and one below every carrier gives -4. `levelOut` is a 4-bit two's complement value.
- R2: With H = 2^BAND_W, carrier k (k = 0 at the bottom to 7 at the top) spans the range (k-4)*H to (k-3)*H. A phase counter p moves one step per tick as 0,1,...,H,H-1,...,1,0,1,..., giving a period of 2H ticks. p starts at 0 and rises after reset. The mode has no effect on p.
- R3: In mode 2'b00, every carrier is non-inverted, with value (k-4)*H + p.
- R4: In mode 2'b01, carriers 0 to 3 (below zero) are inverted, with value (k-4)*H + H - p. Carriers 4 to 7 are non-inverted.
- R5: In mode 2'b10, odd-numbered carriers are inverted and even-numbered carriers (carrier 0 included) are non-inverted.
- R6: Mode 2'b11 behaves exactly like mode 2'b00.
- R7: `switchOut` bit 7 drives switch 1 and bit 0 drives switch 8. The patterns are: +4 = 11001100, +3 = 11000101, +2 = 11000011, +1 = 01011100, 0 = 01010101, -1 = 01010011, -2 = 00111100, -3 = 00110101, -4 = 00110011.
- R8: Exactly four bits of `switchOut` are set at all times.
- R9: Both outputs are registered and change only on a clock edge where `tickIn` is high. Changes to `refIn` or `modeIn` while `tickIn` is low have no effect on the outputs. On a tick, the outputs use the phase value that held before that tick's step.
- R10: Reset (synchronous, active high) sets the level to 0, `switchOut` to 01010101 and the phase to 0, rising.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tickIn | input | 1 | Modulation tick; one phase step and one output update |
| refIn | input | REF_W (12) | Signed reference sample |
| modeIn | input | 2 | Carrier disposition select |
| switchOut | output | 8 | Gate pattern, bit 7 = switch 1 |
| levelOut | output | 4 | Signed output level |

## Verification
The assertions assume that `tickIn` is a plain single-cycle or multi-cycle strobe. They also assume that `refIn` is any 12-bit signed value. No range limit is placed on `refIn`, because saturation is part of the required behaviour. The bench drives inputs only between clock edges. It sweeps random references over the full signed range, mixed with values equal to carrier edges and the two extremes. The mode is re-drawn at random, including the unused code. Random idle gaps with a changed reference test the hold behaviour. Over 600 ticks the phase counter completes more than one full period, so both slopes and both turning points are covered in every mode.

// File: rtl/lsc_pwm_pkg.sv
package lsc_pwm_pkg;

  localparam int NUM_CARRIERS = 8;
  localparam int HALF_CARRIERS = NUM_CARRIERS / 2;

  typedef enum logic [1:0] {
    DISP_INPHASE  = 2'b00,
    DISP_OPPOSED  = 2'b01,
    DISP_ALTERNATE = 2'b10
  } dispMode_e;

  typedef struct packed {
    logic sample;
  } ctlStrobe_t;

  localparam logic [7:0] IDLE_PATTERN = 8'b01010101;

  function automatic logic [7:0] levelPattern(input logic [3:0] lvl);
    logic [7:0] pat;
    case (lvl)
      4'd4:  pat = 8'b11001100;
      4'd3:  pat = 8'b11000101;
      4'd2:  pat = 8'b11000011;
      4'd1:  pat = 8'b01011100;
      4'hF:  pat = 8'b01010011;
      4'hE:  pat = 8'b00111100;
      4'hD:  pat = 8'b00110101;
      4'hC:  pat = 8'b00110011;
      default: pat = IDLE_PATTERN;
    endcase
    return pat;
  endfunction

endpackage

// File: rtl/lsc_pwm_ctrl.sv
module lsc_pwm_ctrl
  import lsc_pwm_pkg::*;
#(
  parameter int BAND_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tickIn,
  output ctlStrobe_t        strobe,
  output logic [BAND_W:0]   phase
);
  localparam int CW = BAND_W + 1;
  localparam logic [CW-1:0] PEAK = CW'(1 << BAND_W);

  logic dirUp;

  assign strobe.sample = tickIn;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= '0;
      dirUp <= 1'b1;
    end else if (tickIn) begin
      if (dirUp) begin
        if (phase == PEAK - 1'b1) dirUp <= 1'b0;
        phase <= phase + 1'b1;
      end else begin
        if (phase == CW'(1)) dirUp <= 1'b1;
        phase <= phase - 1'b1;
      end
    end
  end

  // R2: the phase never leaves the band height
  a_r2_phase_bound: assert property (@(posedge clk) disable iff (rst)
    phase <= PEAK);

  // R2: each tick moves the phase by exactly one count
  a_r2_unit_step: assert property (@(posedge clk) disable iff (rst)
    tickIn |=> (phase == $past(phase) + 1'b1) || (phase == $past(phase) - 1'b1));

  // R2: without a tick the phase holds
  a_r2_phase_hold: assert property (@(posedge clk) disable iff (rst)
    !tickIn |=> $stable(phase));

endmodule

// File: rtl/lsc_pwm_datapath.sv
module lsc_pwm_datapath
  import lsc_pwm_pkg::*;
#(
  parameter int REF_W  = 12,
  parameter int BAND_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  ctlStrobe_t              strobe,
  input  logic [BAND_W:0]         phase,
  input  logic signed [REF_W-1:0] refIn,
  input  logic [1:0]              modeIn,
  output logic [7:0]              switchOut,
  output logic [3:0]              levelOut
);
  localparam int CW     = BAND_W + 1;
  localparam int CARR_W = REF_W + 1;
  localparam int H      = 1 << BAND_W;
  localparam logic [CW-1:0] PEAK = CW'(H);

  logic signed [CARR_W-1:0] refExt;
  logic [NUM_CARRIERS-1:0]  above;
  logic [3:0]               aboveCount;
  logic [3:0]               levelNext;

  assign refExt = {refIn[REF_W-1], refIn};

  for (genvar k = 0; k < NUM_CARRIERS; k++) begin : g_band
    localparam logic signed [CARR_W-1:0] FLOOR = CARR_W'((k - HALF_CARRIERS) * H);
    logic                     mirror;
    logic [CW-1:0]            offset;
    logic signed [CARR_W-1:0] carrier;

    always_comb begin
      case (modeIn)
        DISP_OPPOSED:   mirror = (k < HALF_CARRIERS);
        DISP_ALTERNATE: mirror = ((k % 2) == 1);
        default:        mirror = 1'b0;
      endcase
      offset  = mirror ? (PEAK - phase) : phase;
      carrier = FLOOR + $signed({{(CARR_W-CW){1'b0}}, offset});
    end

    assign above[k] = (refExt > carrier);
  end

  always_comb begin
    aboveCount = '0;
    for (int i = 0; i < NUM_CARRIERS; i++) aboveCount = aboveCount + {3'b0, above[i]};
    levelNext = aboveCount - 4'd4;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      levelOut  <= 4'd0;
      switchOut <= IDLE_PATTERN;
    end else if (strobe.sample) begin
      levelOut  <= levelNext;
      switchOut <= levelPattern(levelNext);
    end
  end

  // R8: four switches conduct in every state
  a_r8_four_on: assert property (@(posedge clk) disable iff (rst)
    $countones(switchOut) == 4);

  // R1: level code stays within -4..+4
  a_r1_level_range: assert property (@(posedge clk) disable iff (rst)
    ($signed(levelOut) >= -4) && ($signed(levelOut) <= 4));

  // R9: outputs hold between ticks
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !strobe.sample |=> $stable(levelOut) && $stable(switchOut));

  // R7: the zero level always shows the idle pattern
  a_r7_zero_pattern: assert property (@(posedge clk) disable iff (rst)
    (levelOut == 4'd0) |-> (switchOut == 8'b01010101));

endmodule

// File: rtl/lsc_pwm_nine.sv
module lsc_pwm_nine
  import lsc_pwm_pkg::*;
#(
  parameter int REF_W  = 12,
  parameter int BAND_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    tickIn,
  input  logic signed [REF_W-1:0] refIn,
  input  logic [1:0]              modeIn,
  output logic [7:0]              switchOut,
  output logic [3:0]              levelOut
);
  ctlStrobe_t      strobe;
  logic [BAND_W:0] phase;

  lsc_pwm_ctrl #(.BAND_W(BAND_W)) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .tickIn (tickIn),
    .strobe (strobe),
    .phase  (phase)
  );

  lsc_pwm_datapath #(.REF_W(REF_W), .BAND_W(BAND_W)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .phase     (phase),
    .refIn     (refIn),
    .modeIn    (modeIn),
    .switchOut (switchOut),
    .levelOut  (levelOut)
  );

endmodule

// File: tb/lsc_pwm_nine_tb.sv
`timescale 1ns/1ps
module lsc_pwm_nine_tb;
  localparam int REF_W = 12;
  localparam int H     = 256;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tickIn = 1'b0;
  logic signed [REF_W-1:0] refIn = '0;
  logic [1:0] modeIn = 2'b00;
  logic [7:0] switchOut;
  logic [3:0] levelOut;

  int checks = 0;
  int errors = 0;
  int ph = 0;
  bit up = 1'b1;
  int expLvl = 0;

  always #2 clk = ~clk;

  lsc_pwm_nine u_dut (
    .clk(clk), .rst(rst), .tickIn(tickIn), .refIn(refIn),
    .modeIn(modeIn), .switchOut(switchOut), .levelOut(levelOut)
  );

  function automatic int modelLevel(input int r, input int m, input int p);
    int n = 0;
    for (int k = 0; k < 8; k++) begin
      bit inv;
      int c;
      inv = (m == 1) ? (k < 4) : (m == 2) ? (k % 2 == 1) : 1'b0;
      c = (k - 4) * H + (inv ? (H - p) : p);
      if (r > c) n++;
    end
    return n - 4;
  endfunction

  function automatic logic [7:0] modelPattern(input int l);
    case (l)
      4:  return 8'b11001100;
      3:  return 8'b11000101;
      2:  return 8'b11000011;
      1:  return 8'b01011100;
      -1: return 8'b01010011;
      -2: return 8'b00111100;
      -3: return 8'b00110101;
      -4: return 8'b00110011;
      default: return 8'b01010101;
    endcase
  endfunction

  function automatic string modeReq(input int m);
    case (m)
      1: return "R4";
      2: return "R5";
      3: return "R6";
      default: return "R3";
    endcase
  endfunction

  task automatic checkOut(input string req, input int lvl);
    int got;
    got = $signed(levelOut);
    checks++;
    if (got != lvl) begin
      errors++;
      $display("FAIL %s level actual %0d expected %0d", req, got, lvl);
    end
    checks++;
    if (switchOut != modelPattern(lvl)) begin
      errors++;
      $display("FAIL R7 switches actual %b expected %b", switchOut, modelPattern(lvl));
    end
    checks++;
    if ($countones(switchOut) != 4) begin
      errors++;
      $display("FAIL R8 ones actual %0d expected 4", $countones(switchOut));
    end
  endtask

  task automatic advanceModel();
    if (up) begin
      if (ph == H - 1) up = 1'b0;
      ph++;
    end else begin
      if (ph == 1) up = 1'b1;
      ph--;
    end
  endtask

  task automatic doTick(input int r, input int m, input string req);
    @(negedge clk);
    refIn = REF_W'(r);
    modeIn = 2'(m);
    tickIn = 1'b1;
    expLvl = modelLevel(r, m, ph);
    @(negedge clk);
    tickIn = 1'b0;
    advanceModel();
    checkOut(req, expLvl);
  endtask

  task automatic idleGap(input int r, input int m);
    @(negedge clk);
    refIn = REF_W'(r);
    modeIn = 2'(m);
    tickIn = 1'b0;
    @(negedge clk);
    checkOut("R9", expLvl);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    checkOut("R10", 0);
    rst = 1'b0;
    // R1 equality at p=0: ref 0 equals carrier 4, not counted
    doTick(0, 0, "R1");
    doTick(256, 0, "R1 R2");
    doTick(2047, 1, "R1");
    doTick(-2048, 2, "R1");
    idleGap(2047, 0);
    doTick(-700, 3, "R6");
    doTick(-700, 1, "R4");
    doTick(500, 2, "R5");
    for (int i = 0; i < 600; i++) begin
      int r, m;
      r = $signed(REF_W'($urandom));
      m = $urandom_range(0, 3);
      if ($urandom_range(0, 3) == 0) r = ($urandom_range(0, 8) - 4) * H;
      doTick(r, m, modeReq(m));
      if ($urandom_range(0, 9) == 0) idleGap($signed(REF_W'($urandom)), $urandom_range(0, 3));
    end
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    ph = 0;
    up = 1'b1;
    expLvl = 0;
    checkOut("R10", 0);
    doTick(1, 0, "R2 R10");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule